// File: doc/BRIEF.md
# Datalogger mission control counters

This block keeps the bookkeeping for a logging mission. A small register file holds the timekeeping registers, a control register, a sample rate register and two status registers. One write port and one combinational read port give access to it. A `sample_tick` input marks each moment at which the surrounding logger would take a sample. The block decides whether that tick is recorded. A recorded tick advances two counters together. The mission counter restarts whenever a mission starts. The lifetime counter only ever grows.

A host can detect tampering with the two counters. It notes the lifetime count when a mission starts. When the mission ends, it subtracts that value from the new lifetime count. If nothing cleared the mission in between, the result equals the mission count. A write to a timekeeping register or to the control register ends the mission at once. A write to a status register does not.

Top module: `mlog_mission_ctl`

Register map with default parameters (`ADDR_W`=4, `NUM_CLK_REGS`=7, `NUM_STAT_REGS`=2):

| Address | Register |
|---|---|
| 0 to 6 | timekeeping |
| 7 | control |
| 8 | sample rate |
| 9 and 10 | status |
| 11 to 15 | unmapped |

## Requirements
- R1: A write of a non-zero value to the sample rate register (address 8) sets `mission_active` and clears `cur_count` to 0 on the clock edge that takes the write. The value can be read back at address 8 afterwards.
- R2: A write of zero to address 8 stores zero. It leaves both `mission_active` and `cur_count` as they were.
- R3: When `sample_tick` is high and `mission_active` is set, both counters rise by one at that edge. When `mission_active` is clear, a tick changes neither counter.
- R4: A write to a timekeeping register (addresses 0 to 6) or to the control register (address 7) clears `mission_active` at that edge. A tick in the same cycle is not counted.
- R5: A write to a status register (addresses 9 and 10) changes neither `mission_active` nor the counting of a tick in the same cycle.
- R6: `life_count` never decreases. No register write clears it. Only the block reset clears it.
- R7: Each counter holds at its all-ones value once it gets there. It does not wrap.
- R8: The two counters move in lockstep. A non-zero rate write in the same cycle as a tick drops that tick from both counters. Over a mission with no clear in between, `cur_count` equals the end value of `life_count` minus its start value.
- R9: After reset, `mission_active` is 0, both counters read 0, and every register reads 0.
- R10: `rd_data` returns the stored value for addresses 0 to 10 and 0 for any address above 10. Writes to addresses above 10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released inside the block through a two-flop synchronizer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| sample_tick | input | 1 | One-cycle pulse marking a sample opportunity |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Register contents at `rd_addr` (combinational) |
| mission_active | output | 1 | Mission-in-progress flag |
| cur_count | output | CNT_W | Samples counted since the last mission start |
| life_count | output | CNT_W | Samples counted since reset |

## Verification
The bench drives the counting path with ticks while idle, ticks during a mission, and ticks that arrive in the same cycle as a rate write, a status write, a timekeeping write or a control write. These cases separate correct gating from a counter that ignores the mission flag, a decode that lets status writes abort, and a start or abort that lets a coincident tick slip into only one counter. A zero rate write in the middle of a mission shows that only non-zero values restart the mission. A long run of ticks drives both counters to saturation. Sweeping the read port over every address, including unmapped writes, shows that the register file stores exactly what the map assigns.

// File: rtl/mlog_pkg.sv
package mlog_pkg;
  typedef enum logic [2:0] {
    KIND_CLOCK,
    KIND_CTRL,
    KIND_RATE,
    KIND_STATUS,
    KIND_NONE
  } reg_kind_e;
endpackage

// File: rtl/mlog_rst_sync.sv
module mlog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mlog_decode.sv
module mlog_decode
  import mlog_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int NUM_CLK_REGS  = 7,
  parameter int NUM_STAT_REGS = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind
);
  localparam int CTRL_ADDR = NUM_CLK_REGS;
  localparam int RATE_ADDR = NUM_CLK_REGS + 1;
  localparam int STAT_BASE = NUM_CLK_REGS + 2;
  localparam int STAT_LAST = STAT_BASE + NUM_STAT_REGS - 1;

  always_comb begin
    if (addr < ADDR_W'(CTRL_ADDR))       kind = KIND_CLOCK;
    else if (addr == ADDR_W'(CTRL_ADDR)) kind = KIND_CTRL;
    else if (addr == ADDR_W'(RATE_ADDR)) kind = KIND_RATE;
    else if (addr <= ADDR_W'(STAT_LAST)) kind = KIND_STATUS;
    else                                 kind = KIND_NONE;
  end
endmodule

// File: rtl/mlog_regbank.sv
module mlog_regbank #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic              we;
    logic [DATA_W-1:0] d;

    always_comb begin
      we = wr_en && (wr_addr == ADDR_W'(gi));
      d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[gi] <= '0;
      else if (we) regs_q[gi] <= d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = regs_q[i];
    end
  end
endmodule

// File: rtl/mlog_sat_counter.sv
module mlog_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             at_max, en;

  always_comb begin
    at_max  = &count_q;
    en      = clr || (inc && !at_max);
    count_d = clr ? '0 : count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  count_q <= '0;
    else if (en) count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/mlog_mission.sv
module mlog_mission
  import mlog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  reg_kind_e wr_kind,
  input  logic      wr_nonzero,
  input  logic      sample_tick,
  output logic      mission_q,
  output logic      count_en,
  output logic      restart
);
  logic abort, mission_d, mission_en;

  always_comb begin
    abort      = wr_en && (wr_kind == KIND_CLOCK || wr_kind == KIND_CTRL);
    restart    = wr_en && (wr_kind == KIND_RATE) && wr_nonzero;
    count_en   = mission_q && sample_tick && !abort && !restart;
    mission_en = abort || restart;
    mission_d  = restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mission_q <= 1'b0;
    else if (mission_en) mission_q <= mission_d;
  end
endmodule

// File: rtl/mlog_mission_ctl.sv
module mlog_mission_ctl
  import mlog_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 16,
  parameter int NUM_CLK_REGS  = 7,
  parameter int NUM_STAT_REGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sample_tick,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              mission_active,
  output logic [CNT_W-1:0]  cur_count,
  output logic [CNT_W-1:0]  life_count
);
  localparam int NUM_REGS = NUM_CLK_REGS + 2 + NUM_STAT_REGS;

  logic      rst_sync_n;
  reg_kind_e wr_kind;
  logic      count_en, restart;

  mlog_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mlog_decode #(
    .ADDR_W        (ADDR_W),
    .NUM_CLK_REGS  (NUM_CLK_REGS),
    .NUM_STAT_REGS (NUM_STAT_REGS)
  ) u_dec (
    .addr (wr_addr),
    .kind (wr_kind)
  );

  mlog_regbank #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  mlog_mission u_mis (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_en),
    .wr_kind     (wr_kind),
    .wr_nonzero  (|wr_data),
    .sample_tick (sample_tick),
    .mission_q   (mission_active),
    .count_en    (count_en),
    .restart     (restart)
  );

  mlog_sat_counter #(.CNT_W(CNT_W)) u_cur (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (restart),
    .inc   (count_en),
    .count (cur_count)
  );

  mlog_sat_counter #(.CNT_W(CNT_W)) u_life (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (1'b0),
    .inc   (count_en),
    .count (life_count)
  );
endmodule

// File: rtl/mlog_mission_chk.sv
module mlog_mission_chk #(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 16,
  parameter int NUM_CLK_REGS  = 7,
  parameter int NUM_STAT_REGS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              mission_active,
  input logic [CNT_W-1:0]  cur_count,
  input logic [CNT_W-1:0]  life_count
);
  localparam int CTRL_ADDR = NUM_CLK_REGS;
  localparam int RATE_ADDR = NUM_CLK_REGS + 1;
  localparam int STAT_BASE = NUM_CLK_REGS + 2;
  localparam int STAT_LAST = STAT_BASE + NUM_STAT_REGS - 1;

  logic is_abort, is_start, is_status;
  always_comb begin
    is_abort  = wr_en && (wr_addr <= ADDR_W'(CTRL_ADDR));
    is_start  = wr_en && (wr_addr == ADDR_W'(RATE_ADDR)) && (wr_data != '0);
    is_status = wr_en && (wr_addr >= ADDR_W'(STAT_BASE)) && (wr_addr <= ADDR_W'(STAT_LAST));
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_start |=> (mission_active && cur_count == '0));

  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_abort |=> !mission_active);

  p_status_keeps_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_status |=> (mission_active == $past(mission_active)));

  p_life_never_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    life_count >= $past(life_count));

  p_idle_no_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mission_active) |-> $stable(life_count));

  p_cur_saturates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&$past(cur_count)) && !$past(is_start)) |-> (&cur_count));

  p_lockstep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count == $past(cur_count) + CNT_W'(1) && cur_count != '0)
      |-> (life_count == $past(life_count) + CNT_W'(1) || (&$past(life_count))));
endmodule

bind mlog_mission_ctl mlog_mission_chk #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .CNT_W         (CNT_W),
  .NUM_CLK_REGS  (NUM_CLK_REGS),
  .NUM_STAT_REGS (NUM_STAT_REGS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .wr_en          (wr_en),
  .wr_addr        (wr_addr),
  .wr_data        (wr_data),
  .mission_active (mission_active),
  .cur_count      (cur_count),
  .life_count     (life_count)
);

// File: tb/mlog_mission_ctl_tb.sv
module mlog_mission_ctl_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CW = 6;
  localparam int NREG = 11;
  localparam logic [CW-1:0] CMAX = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          sample_tick = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          mission_active;
  logic [CW-1:0] cur_count, life_count;

  always #4 clk = ~clk;

  mlog_mission_ctl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sample_tick(sample_tick), .rd_addr(rd_addr), .rd_data(rd_data),
    .mission_active(mission_active), .cur_count(cur_count), .life_count(life_count)
  );

  typedef struct {
    logic [CW-1:0] cur;
    logic [CW-1:0] life;
    logic          mis;
    logic [DW-1:0] rd;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic          m_mis = 1'b0;
  logic [CW-1:0] m_cur = '0, m_life = '0;
  logic [DW-1:0] m_regs [NREG];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and predict the state after the edge
  task automatic step(input bit we, input int addr, input int data, input bit tick,
                      input int raddr, input string tag);
    bit abort, start, cnt;
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_addr = AW'(addr); wr_data = DW'(data);
    sample_tick = tick; rd_addr = AW'(raddr);
    abort = we && addr <= 7;
    start = we && addr == 8 && data != 0;
    cnt   = m_mis && tick && !abort && !start;
    if (cnt) begin
      if (m_cur != CMAX) m_cur = m_cur + 1'b1;
      if (m_life != CMAX) m_life = m_life + 1'b1;
    end
    if (start) begin m_cur = '0; m_mis = 1'b1; end
    if (abort) m_mis = 1'b0;
    if (we && addr < NREG) m_regs[addr] = DW'(data);
    e.cur = m_cur; e.life = m_life; e.mis = m_mis;
    e.rd = (raddr < NREG) ? m_regs[raddr] : '0;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(mission_active == e.mis, e.tag, "mission", int'(mission_active), int'(e.mis));
        check(cur_count == e.cur, e.tag, "cur", int'(cur_count), int'(e.cur));
        check(life_count == e.life, e.tag, "life", int'(life_count), int'(e.life));
        check(rd_data == e.rd, e.tag, "rd_data", int'(rd_data), int'(e.rd));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] life_start;
    for (int i = 0; i < NREG; i++) m_regs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(0, 0, 0, 0, 8, "R9");
    step(0, 0, 0, 0, 3, "R9");
    step(0, 0, 0, 1, 0, "R3_idle_tick");
    step(1, 8, 0, 0, 8, "R2_zero_idle");
    step(1, 8, 5, 0, 8, "R1_start");
    life_start = m_life;
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 8, "R3_count");
    step(1, 9, 8'hA5, 1, 9, "R5_status_tick");
    step(1, 10, 8'h3C, 1, 10, "R5_status2_tick");
    step(1, 12, 8'hFF, 1, 12, "R10_unmapped");
    step(0, 0, 0, 0, 12, "R8");
    @(negedge clk); #1;
    check(cur_count == life_count - life_start, "R8", "tamper",
          int'(cur_count), int'(life_count - life_start));
    step(1, 2, 8'h11, 1, 2, "R4_clock_abort");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R3_after_abort");
    step(1, 8, 3, 0, 8, "R1_restart_R6");
    step(0, 0, 0, 1, 0, "R3");
    step(1, 8, 7, 1, 8, "R8_start_tick");
    step(0, 0, 0, 1, 0, "R3");
    step(1, 8, 0, 1, 8, "R2_zero_in_mission");
    step(0, 0, 0, 1, 0, "R2_keeps_counting");
    step(1, 7, 8'h40, 1, 7, "R4_ctrl_abort");
    step(0, 0, 0, 1, 7, "R6_life_kept");
    step(1, 8, 1, 0, 8, "R1");
    for (int i = 0; i < 70; i++) step(0, 0, 0, 1, 0, "R7_saturate");
    step(1, 8, 2, 0, 0, "R7_cur_clear_life_hold");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, i, "R10_read");
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule